// File: doc/BRIEF.md
# Vulnerability-aware task dispatcher

This block hands task descriptors from a shared first-in-first-out task queue to the cores of a cluster. A core that is idle raises its fetch request. The dispatcher picks one requester per cycle in rotating order. It then reads the head of the queue without removing it. It also looks up the picked core's vulnerability figure for the head task's type in an external table. A high figure means that core tends to produce timing errors on that kind of work.

If the figure is above a programmable vulnerability threshold, the core normally declines the task. The task stays at the head of the queue for another core, and the declining core gets a reject response. Each core has its own escape counter, which counts its consecutive refusals. Once that counter reaches a programmable escape limit, the core must accept the head task whatever its figure. This prevents starvation. Every acceptance clears the counter.

A request made while the queue is empty receives an empty response and changes no counter. Executing tasks and updating the vulnerability table are the business of other blocks.

Top module: `vtask_dispatch`

## Requirements
- R1: Reset state. After reset no response is raised and no pop is issued. The vulnerability threshold resets to all ones, the escape limit to zero and every escape counter to zero, so the first request to a non-empty queue is granted.
- R2: At most one response (grant, reject or empty) is raised per cycle, across all cores and all kinds.
- R3: If the picked core's vulnerability is not above the threshold and the queue is not empty, the task is granted. In the decision cycle `q_pop_o` is high. In the next cycle the core's bit of `gnt_o` is high, and `desc_data_o`/`desc_type_o` carry the head entry.
- R4: If the vulnerability is strictly above the threshold and that core's escape counter is below the escape limit, the core's bit of `rej_o` rises in the next cycle. No pop is issued and the counter increases by one.
- R5: If the vulnerability is above the threshold but the counter has reached the escape limit (or exceeds a lowered limit), the task is granted as in R3.
- R6: Every grant clears the granted core's escape counter to zero.
- R7: A request while `q_empty_i` is high raises that core's bit of `emp_o` in the next cycle. It issues no pop and leaves every counter unchanged.
- R8: Simultaneous requests are served one per cycle. The search starts at the core after the one served last (core 0 after reset) and wraps around. Any served request, of any response kind, moves the start point.
- R9: Escape counters are kept per core; a decision for one core never changes another core's counter.
- R10: In a decision cycle `tbl_core_o` holds the picked core index and `tbl_type_o` the head task's type. `tbl_vuln_i` is read in that same cycle.
- R11: A write with `cfg_sel_i`=0 loads the vulnerability threshold from `cfg_wdata_i`. With `cfg_sel_i`=1 it loads the escape limit from the low ECW bits. A write applies to decisions from the next cycle on; a decision in the write cycle uses the old value.
- R12: A pop is issued only in a cycle whose decision is a grant, and every grant follows exactly one pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCORES | Per-core fetch request |
| gnt_o | output | NCORES | Per-core grant response, one cycle after decision |
| rej_o | output | NCORES | Per-core reject (escape) response |
| emp_o | output | NCORES | Per-core queue-empty response |
| desc_data_o | output | DW | Payload of the granted descriptor |
| desc_type_o | output | TW | Type of the granted descriptor |
| q_empty_i | input | 1 | Task queue is empty |
| q_head_type_i | input | TW | Type of the head descriptor (peek) |
| q_head_data_i | input | DW | Payload of the head descriptor (peek) |
| q_pop_o | output | 1 | Remove the head descriptor at this clock edge |
| tbl_core_o | output | CW | Vulnerability table lookup: core index |
| tbl_type_o | output | TW | Vulnerability table lookup: task type |
| tbl_vuln_i | input | VW | Vulnerability value returned by the table |
| cfg_we_i | input | 1 | Threshold register write enable |
| cfg_sel_i | input | 1 | 0: vulnerability threshold, 1: escape limit |
| cfg_wdata_i | input | VW | Threshold write data |

## Verification
Two events often meet in one edge. A threshold write can land in the same cycle as a decision. A core whose escape counter sits exactly at the limit can compete with other requesters in the rotation. The random phase writes both thresholds at random while several cores request every cycle over a shallow queue, so both collisions recur often. A directed sequence walks one core up to the limit and then changes the limit in its decision cycle. Every response is compared with a bench model. The model applies a write only after the decision it shares a cycle with, and it tracks the counters and the rotation independently.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_GRANT = 2'd1,
        DEC_SKIP  = 2'd2,
        DEC_EMPTY = 2'd3
    } dec_e;

    localparam logic CFG_VULN_THR = 1'b0;
    localparam logic CFG_ESC_LIM  = 1'b1;
endpackage

// File: rtl/vtd_rr_arb.sv
module vtd_rr_arb #(
    parameter int N = 4,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  gnt,
    output logic [CW-1:0] idx,
    output logic          valid
);
    logic [CW-1:0] ptr_d, ptr_q;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(ptr_q) + i) % N;
            if (!valid && req[j]) begin
                valid = 1'b1;
                idx   = CW'(j);
            end
        end
        gnt   = valid ? (N'(1) << idx) : '0;
        ptr_d = (adv && valid) ? CW'((int'(idx) + 1) % N) : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    a_r8_pick_is_requester: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (($countones(gnt) == 1) && ((gnt & ~req) == '0)));
    a_r8_no_pick_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !valid);
endmodule

// File: rtl/vtd_esc_bank.sv
module vtd_esc_bank #(
    parameter int N   = 4,
    parameter int ECW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          inc,
    input  logic [N-1:0]          clr,
    input  logic [ECW-1:0]        lim,
    output logic [N-1:0][ECW-1:0] cnt
);
    for (genvar g = 0; g < N; g++) begin : g_core
        logic [ECW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (clr[g])      cnt_d = '0;
            else if (inc[g]) cnt_d = cnt_q + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign cnt[g] = cnt_q;

        a_r4_inc_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
            inc[g] |-> (cnt_q < lim));
        a_r9_inc_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(inc[g] && clr[g]));
        a_r6_clear_reaches_zero: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> (cnt_q == '0));
    end
endmodule

// File: rtl/vtask_dispatch.sv
module vtask_dispatch
    import vtd_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NTYPES = 4,
    parameter int VW     = 8,
    parameter int ECW    = 4,
    parameter int DW     = 16,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int TW    = (NTYPES > 1) ? $clog2(NTYPES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] req_i,
    output logic [NCORES-1:0] gnt_o,
    output logic [NCORES-1:0] rej_o,
    output logic [NCORES-1:0] emp_o,
    output logic [DW-1:0]     desc_data_o,
    output logic [TW-1:0]     desc_type_o,
    input  logic              q_empty_i,
    input  logic [TW-1:0]     q_head_type_i,
    input  logic [DW-1:0]     q_head_data_i,
    output logic              q_pop_o,
    output logic [CW-1:0]     tbl_core_o,
    output logic [TW-1:0]     tbl_type_o,
    input  logic [VW-1:0]     tbl_vuln_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [VW-1:0]     cfg_wdata_i
);
    typedef struct packed {
        logic [NCORES-1:0] gnt;
        logic [NCORES-1:0] rej;
        logic [NCORES-1:0] emp;
        logic [DW-1:0]     data;
        logic [TW-1:0]     ttype;
        logic [VW-1:0]     vthr;
        logic [ECW-1:0]    elim;
    } st_t;

    st_t st_d, st_q;

    logic [NCORES-1:0]          pick_oh;
    logic [CW-1:0]              pick_idx;
    logic                       pick_vld;
    logic [NCORES-1:0]          esc_inc, esc_clr;
    logic [NCORES-1:0][ECW-1:0] esc_cnt;
    dec_e                       dec;

    vtd_rr_arb #(.N(NCORES)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_i),
        .adv   (pick_vld),
        .gnt   (pick_oh),
        .idx   (pick_idx),
        .valid (pick_vld)
    );

    vtd_esc_bank #(.N(NCORES), .ECW(ECW)) u_esc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (esc_inc),
        .clr   (esc_clr),
        .lim   (st_q.elim),
        .cnt   (esc_cnt)
    );

    assign tbl_core_o = pick_idx;
    assign tbl_type_o = q_head_type_i;

    always_comb begin
        logic too_risky, may_escape;
        too_risky  = tbl_vuln_i > st_q.vthr;
        may_escape = esc_cnt[pick_idx] < st_q.elim;

        if (!pick_vld)                    dec = DEC_IDLE;
        else if (q_empty_i)               dec = DEC_EMPTY;
        else if (too_risky && may_escape) dec = DEC_SKIP;
        else                              dec = DEC_GRANT;

        st_d     = st_q;
        st_d.gnt = (dec == DEC_GRANT) ? pick_oh : '0;
        st_d.rej = (dec == DEC_SKIP)  ? pick_oh : '0;
        st_d.emp = (dec == DEC_EMPTY) ? pick_oh : '0;
        if (dec == DEC_GRANT) begin
            st_d.data  = q_head_data_i;
            st_d.ttype = q_head_type_i;
        end
        if (cfg_we_i) begin
            if (cfg_sel_i == CFG_VULN_THR) st_d.vthr = cfg_wdata_i;
            else                           st_d.elim = cfg_wdata_i[ECW-1:0];
        end

        esc_inc = (dec == DEC_SKIP)  ? pick_oh : '0;
        esc_clr = (dec == DEC_GRANT) ? pick_oh : '0;
        q_pop_o = (dec == DEC_GRANT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.vthr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o       = st_q.gnt;
    assign rej_o       = st_q.rej;
    assign emp_o       = st_q.emp;
    assign desc_data_o = st_q.data;
    assign desc_type_o = st_q.ttype;

    a_r2_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_o, rej_o, emp_o}));
    a_r12_pop_then_grant: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop_o |=> ($countones(gnt_o) == 1));
    a_r12_grant_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |-> $past(q_pop_o));
    a_r7_empty_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty_i |-> !q_pop_o);
    a_r7_empty_resp_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (|emp_o) |-> $stable(esc_cnt));
    a_r3_pop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop_o |-> (|req_i));
endmodule

// File: tb/tb_vtask_dispatch.sv
module tb_vtask_dispatch;
    localparam int NC = 4;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req_i = '0;
    logic [NC-1:0] gnt_o, rej_o, emp_o;
    logic [15:0]   desc_data_o;
    logic [1:0]    desc_type_o;
    logic          q_empty_i = 1'b1;
    logic [1:0]    q_head_type_i = '0;
    logic [15:0]   q_head_data_i = '0;
    logic          q_pop_o;
    logic [1:0]    tbl_core_o, tbl_type_o;
    logic [7:0]    tbl_vuln_i;
    logic          cfg_we_i = 1'b0;
    logic          cfg_sel_i = 1'b0;
    logic [7:0]    cfg_wdata_i = '0;

    always #2.5ns clk = ~clk;

    vtask_dispatch dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o), .rej_o(rej_o),
        .emp_o(emp_o), .desc_data_o(desc_data_o), .desc_type_o(desc_type_o),
        .q_empty_i(q_empty_i), .q_head_type_i(q_head_type_i),
        .q_head_data_i(q_head_data_i), .q_pop_o(q_pop_o),
        .tbl_core_o(tbl_core_o), .tbl_type_o(tbl_type_o), .tbl_vuln_i(tbl_vuln_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i)
    );

    // vulnerability table model, indexed core*NT+type
    logic [7:0] vtab [NC*NT];
    always_comb tbl_vuln_i = vtab[int'(tbl_core_o)*NT + int'(tbl_type_o)];

    // task queue model
    logic [15:0] qd [256];
    logic [1:0]  qt [256];
    logic [7:0]  qhd = '0, qtl = '0;

    // reference state
    int mcnt [NC];
    int mvthr = 255;
    int melim = 0;
    int mptr  = 0;
    int nvec  = 0;
    int nerr  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] ty, input logic [15:0] d);
        if (qtl + 8'd1 != qhd) begin
            qd[qtl] = d;
            qt[qtl] = ty;
            qtl = qtl + 8'd1;
        end
    endtask

    // one decision cycle; called at a negedge, returns at the following negedge
    task automatic step(input logic [NC-1:0] rq, input logic we, input logic sel, input logic [7:0] wd);
        bit any, emp;
        int win, kind, v;
        logic [NC-1:0] oh;
        logic [15:0]   hd;
        logic [1:0]    ht;
        req_i = rq; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
        emp = (qhd == qtl);
        q_empty_i = emp;
        hd = qd[qhd]; ht = qt[qhd];
        q_head_data_i = hd; q_head_type_i = ht;
        any = (rq != '0);
        win = 0;
        for (int i = NC - 1; i >= 0; i--) if (rq[(mptr + i) % NC]) win = (mptr + i) % NC;
        oh = any ? (NC'(1) << win) : '0;
        kind = 0;
        if (any) begin
            if (emp) kind = 3;
            else begin
                v = vtab[win*NT + int'(ht)];
                if (v > mvthr && mcnt[win] < melim) kind = 2;
                else kind = 1;
            end
        end
        #1;
        chk(q_pop_o == (kind == 1), "R12 pop", q_pop_o, kind == 1);
        if (any && !emp) begin
            chk(tbl_core_o == 2'(win), "R10 lookup core (R8 order)", tbl_core_o, win);
            chk(tbl_type_o == ht, "R10 lookup type", tbl_type_o, ht);
        end
        @(posedge clk);
        @(negedge clk);
        chk(gnt_o == ((kind == 1) ? oh : '0), "R3 R5 grant", gnt_o, (kind == 1) ? oh : '0);
        chk(rej_o == ((kind == 2) ? oh : '0), "R4 reject", rej_o, (kind == 2) ? oh : '0);
        chk(emp_o == ((kind == 3) ? oh : '0), "R7 empty", emp_o, (kind == 3) ? oh : '0);
        if (kind == 1) chk({desc_type_o, desc_data_o} == {ht, hd}, "R3 descriptor",
                           {desc_type_o, desc_data_o}, {ht, hd});
        // R6 R9: only the picked core's counter moves
        if (kind == 2) mcnt[win]++;
        if (kind == 1) begin mcnt[win] = 0; qhd = qhd + 8'd1; end
        if (any) mptr = (win + 1) % NC;
        // R11: write applied after the decision of its own cycle
        if (we) begin
            if (sel) melim = int'(wd[3:0]);
            else     mvthr = int'(wd);
        end
        req_i = '0; cfg_we_i = 1'b0;
    endtask

    initial begin
        #(5ns * 190000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NC*NT; i++) vtab[i] = 8'd10;
        for (int i = 0; i < NC; i++) mcnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        chk(gnt_o == '0 && rej_o == '0 && emp_o == '0, "R1 responses idle", {gnt_o, rej_o, emp_o}, 0);
        chk(q_pop_o == 1'b0, "R1 no pop", q_pop_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset thresholds grant even the worst figure
        vtab[0] = 8'hFF;
        push(2'd0, 16'hA001);
        step(4'b0001, 0, 0, 0);
        // R11 R4 R5: limit 3, threshold 100, core 0 escapes three times then must take it
        step(4'b0000, 1, 0, 8'd100);
        step(4'b0000, 1, 1, 8'd3);
        vtab[0] = 8'd200;
        push(2'd0, 16'hB002);
        push(2'd0, 16'hB003);
        repeat (4) step(4'b0001, 0, 0, 0);
        // R6: counter cleared, next one rejected again
        step(4'b0001, 0, 0, 0);
        // R7: empty leaves counter at 1
        qhd = qtl;
        step(4'b0001, 0, 0, 0);
        push(2'd0, 16'hB004);
        // R11: limit lowered to 1 in the decision cycle; decision still uses 3
        step(4'b0001, 1, 1, 8'd1);
        step(4'b0001, 0, 0, 0);
        // R8 R9: all cores at once, rotating service
        for (int i = 0; i < 6; i++) push(2'(i), 16'hC000 + 16'(i));
        repeat (6) step(4'b1111, 0, 0, 0);
        // random phase
        for (int i = 0; i < NC*NT; i++) vtab[i] = 8'($urandom);
        for (int n = 0; n < 3000; n++) begin
            logic [NC-1:0] rq;
            logic we, sel;
            logic [7:0] wd;
            if ($urandom % 3 != 0) push(2'($urandom), 16'($urandom));
            rq  = NC'($urandom);
            we  = ($urandom % 16 == 0);
            sel = 1'($urandom);
            wd  = sel ? 8'($urandom % 6) : 8'($urandom);
            if (n % 500 == 0) for (int i = 0; i < NC*NT; i++) vtab[i] = 8'($urandom);
            step(rq, we, sel, wd);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule